// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block brings a double-data-rate graphics DRAM from reset to a usable state. After the controller's reset is released it holds the clock enable low while the clock settles. It then raises clock enable with a no-operation command and plays a fixed list of commands onto the command, bank-address and address pins. The list is: precharge all banks, write the extended mode register to enable the on-die DLL, write the mode register with the DLL-reset bit set, precharge all banks again, run a programmable number of auto-refreshes, and write the mode register a last time with DLL reset cleared. Each command is spaced by its own minimum gap. The block raises `init_done` once the last mode write has settled and the DLL has had its lock time since it was reset.

Both mode-register words are built from parameters: CAS latency, burst length, burst type and output driver strength. Illegal or reserved choices stop elaboration. When the system changes the DRAM clock frequency, the controller pulses `restart` while `init_done` is high. The block then repeats the sequence from the DLL-reset mode write onward, including the lock wait. Clock enable stays high during the repeat, and the DLL-enable write is not issued again.

Top module: `dram_init_seq`

## Requirements
- R1: After reset release, `cke` is 0 and the command is NOP for `STABLE_CYC` cycles. In cycle `STABLE_CYC`, `cke` is 1 with NOP. The first command follows one cycle later. `cke` never falls again until the next reset.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP 0111, precharge 0010, auto-refresh 0001, mode write 0000.
- R3: The commands are issued in this order: precharge, extended mode write, mode write with DLL reset, precharge, `N_REF` auto-refreshes, and a final mode write.
- R4: Each precharge drives bank 0 and sets only address bit `AP_BIT` (the all-banks flag). Refresh drives bank 0 and address 0.
- R5: The extended mode write drives bank 1. A0 is 0 (DLL enabled), A1 is `DRIVE[0]` and A6 is `DRIVE[1]`. All other address bits are 0.
- R6: Each mode write drives bank 0. A2..A0 carry the burst code (001 for 2, 010 for 4, 011 for 8, 111 for full page). A3 carries the burst type (1 = interleave), A6..A4 carry the CAS latency in binary, and A7 is 0. A8 is 1 on the DLL-reset write and 0 on the final write. Higher bits are 0.
- R7: The next command follows exactly `T_RP` cycles after a precharge, `T_MRD` cycles after either mode write, and `T_RFC` cycles after a refresh. `T_MRD` is at least 2.
- R8: `init_done` rises in the cycle that is the later of two points: the DLL-reset write plus `LOCK_CYC`, and the final mode write plus `T_MRD`.
- R9: While `init_done` is high, the command is NOP and `cke` is 1.
- R10: A `restart` sampled while `init_done` is high clears `init_done` in the next cycle. The DLL-reset mode write follows one cycle after that. R3, R7 and R8 then apply again from that write onward.
- R11: A `restart` sampled while `init_done` is low has no effect on the command stream or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Rerun from DLL reset (frequency change) |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete |

## Verification
The bench builds two instances with short timings. The first uses a stable wait of 12, a lock time of 24, precharge 3, refresh 5, mode gap 2 and two refreshes, with interleaved bursts of 8, CAS latency 3 and weak drive. Here the lock wait decides when `init_done` rises. The second uses a stable wait of 5, a lock time of 4, precharge 2, refresh 3, mode gap 3 and three refreshes, with full-page sequential bursts and CAS latency 5. Here the mode-write gap decides it. Together the two instances reach every burst, type and latency field bit and both outcomes of the done-timing maximum. A command monitor recomputes every expected field, gap and done cycle arithmetically from the parameters. It does this across a restart ignored in mid-sequence and two accepted restarts.

// File: rtl/dram_init_pkg.sv
// Shared encodings for the DRAM initialization sequencer.
// Assumes: commands are driven as {cs_n, ras_n, cas_n, we_n}.
package dram_init_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } cmd_e;

    typedef enum logic [3:0] {
        ST_STABLE,
        ST_PRE_A,
        ST_EMRS,
        ST_MRS_DLL,
        ST_PRE_B,
        ST_REF,
        ST_MRS_FIN,
        ST_LOCK,
        ST_DONE
    } step_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_init_timer.sv
// Loadable down-counter that saturates at zero.
// Used for the command gap/stable wait and for the DLL lock wait.
// Assumes: load has priority over counting; RST_VAL fits in W bits.
module dram_init_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= W'(RST_VAL);
        else if (load)           cnt_q <= value;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dram_init_mode_words.sv
// Builds the mode-register and extended-mode-register address words
// from parameters, and rejects reserved choices at elaboration.
// Assumes: BURST_LEN 0 means full page; DRIVE bit0 -> A1, bit1 -> A6.
// The DLL-reset bit (A8) is added by the sequencer.
module dram_init_mode_words #(
    parameter int unsigned CAS_LAT    = 4,
    parameter int unsigned BURST_LEN  = 4,
    parameter int unsigned BURST_TYPE = 0,
    parameter int unsigned DRIVE      = 0,
    parameter int unsigned ADDR_W     = 12
) (
    output logic [ADDR_W-1:0] mrs_word,
    output logic [ADDR_W-1:0] emrs_word
);

    function automatic logic [2:0] burst_code(input int unsigned bl);
        case (bl)
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            0:       return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    localparam logic [2:0] BL_CODE = burst_code(BURST_LEN);

    localparam logic [ADDR_W-1:0] MRS_W =
        ADDR_W'(BL_CODE) | (ADDR_W'(BURST_TYPE) << 3) | (ADDR_W'(CAS_LAT) << 4);
    localparam logic [ADDR_W-1:0] EMRS_W =
        (ADDR_W'(DRIVE % 2) << 1) | (ADDR_W'(DRIVE / 2) << 6);

    if (CAS_LAT < 3 || CAS_LAT > 5) begin : g_bad_cl
        $error("CAS_LAT must be 3, 4 or 5");
    end
    if (BL_CODE == 3'b000) begin : g_bad_bl
        $error("BURST_LEN must be 2, 4, 8 or 0 (full page)");
    end
    if (BURST_TYPE > 1 || (BURST_LEN == 0 && BURST_TYPE != 0)) begin : g_bad_bt
        $error("BURST_TYPE invalid; full page needs sequential");
    end
    if (DRIVE > 1) begin : g_bad_drv
        $error("DRIVE code reserved");
    end
    if (ADDR_W < 9) begin : g_bad_aw
        $error("ADDR_W must reach A8");
    end

    assign mrs_word  = MRS_W;
    assign emrs_word = EMRS_W;

endmodule

// File: rtl/dram_init_seq.sv
// DRAM power-up initialization sequencer.
// Holds CKE low for STABLE_CYC cycles, then plays precharge, EMRS (DLL on),
// MRS (DLL reset), precharge, N_REF refreshes and a final MRS, each spaced by
// its gap; raises init_done once the DLL lock wait has also expired.
// A restart while done reruns from the DLL-reset MRS.
// Assumes: clk is already stable when rst_n is released.
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 40000,
    parameter int unsigned LOCK_CYC   = 200,
    parameter int unsigned T_RP       = 4,
    parameter int unsigned T_RFC      = 17,
    parameter int unsigned T_MRD      = 2,
    parameter int unsigned N_REF      = 2,
    parameter int unsigned CAS_LAT    = 4,
    parameter int unsigned BURST_LEN  = 4,
    parameter int unsigned BURST_TYPE = 0,
    parameter int unsigned DRIVE      = 0,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned AP_BIT     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int unsigned GMAX = max_of(max_of(STABLE_CYC, T_RFC), max_of(T_RP, T_MRD));
    localparam int unsigned GW   = $clog2(GMAX + 1);
    localparam int unsigned LW   = $clog2(LOCK_CYC + 1);
    localparam int unsigned RW   = $clog2(N_REF + 1);
    localparam logic [GW-1:0] GAP_RP  = GW'(T_RP - 1);
    localparam logic [GW-1:0] GAP_RFC = GW'(T_RFC - 1);
    localparam logic [GW-1:0] GAP_MRD = GW'(T_MRD - 1);
    localparam logic [ADDR_W-1:0] AP_WORD  = ADDR_W'(1) << AP_BIT;
    localparam logic [ADDR_W-1:0] DLL_BIT  = ADDR_W'(1) << 8;

    if (T_MRD < 2 || N_REF < 2 || LOCK_CYC < 1 || STABLE_CYC < 1 ||
        T_RP < 1 || T_RFC < 1 || AP_BIT >= ADDR_W) begin : g_bad_timing
        $error("timing or width parameter out of range");
    end

    logic [ADDR_W-1:0] mrs_word, emrs_word;
    logic              gap_zero, lock_zero;
    logic              gap_load, lock_load;
    logic [GW-1:0]     gap_val;

    step_e             step_q, step_n;
    cmd_e              cmd_q, cmd_n;
    logic [BA_W-1:0]   ba_q, ba_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              cke_q, cke_n, done_q, done_n;
    logic [RW-1:0]     ref_q, ref_n;

    dram_init_mode_words #(
        .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .BURST_TYPE(BURST_TYPE),
        .DRIVE(DRIVE), .ADDR_W(ADDR_W)
    ) u_words (
        .mrs_word(mrs_word), .emrs_word(emrs_word)
    );

    // Gap timer; its reset value doubles as the clock-stable wait.
    dram_init_timer #(.W(GW), .RST_VAL(STABLE_CYC - 1)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .value(gap_val), .zero(gap_zero)
    );

    // DLL lock timer, started by the DLL-reset mode write.
    dram_init_timer #(.W(LW), .RST_VAL(0)) u_lock (
        .clk(clk), .rst_n(rst_n), .load(lock_load), .value(LW'(LOCK_CYC - 1)),
        .zero(lock_zero)
    );

    // Next-step decode: issue one command when the gap has elapsed.
    always_comb begin
        step_n    = step_q;
        cmd_n     = CMD_NOP;
        ba_n      = '0;
        addr_n    = '0;
        cke_n     = cke_q;
        done_n    = done_q;
        ref_n     = ref_q;
        gap_load  = 1'b0;
        gap_val   = '0;
        lock_load = 1'b0;
        case (step_q)
            ST_STABLE: if (gap_zero) begin
                cke_n  = 1'b1;
                step_n = ST_PRE_A;
            end
            ST_PRE_A, ST_PRE_B: if (gap_zero) begin
                cmd_n    = CMD_PRE;
                addr_n   = AP_WORD;
                gap_load = 1'b1;
                gap_val  = GAP_RP;
                ref_n    = RW'(N_REF);
                step_n   = (step_q == ST_PRE_A) ? ST_EMRS : ST_REF;
            end
            ST_EMRS: if (gap_zero) begin
                cmd_n    = CMD_MRS;
                ba_n     = BA_W'(1);
                addr_n   = emrs_word;
                gap_load = 1'b1;
                gap_val  = GAP_MRD;
                step_n   = ST_MRS_DLL;
            end
            ST_MRS_DLL: if (gap_zero) begin
                cmd_n     = CMD_MRS;
                addr_n    = mrs_word | DLL_BIT;
                gap_load  = 1'b1;
                gap_val   = GAP_MRD;
                lock_load = 1'b1;
                step_n    = ST_PRE_B;
            end
            ST_REF: if (gap_zero) begin
                cmd_n    = CMD_REF;
                gap_load = 1'b1;
                gap_val  = GAP_RFC;
                ref_n    = ref_q - 1'b1;
                if (ref_q == RW'(1)) step_n = ST_MRS_FIN;
            end
            ST_MRS_FIN: if (gap_zero) begin
                cmd_n    = CMD_MRS;
                addr_n   = mrs_word;
                gap_load = 1'b1;
                gap_val  = GAP_MRD;
                step_n   = ST_LOCK;
            end
            ST_LOCK: if (gap_zero && lock_zero) begin
                done_n = 1'b1;
                step_n = ST_DONE;
            end
            ST_DONE: if (restart) begin
                done_n = 1'b0;
                step_n = ST_MRS_DLL;
            end
            default: step_n = ST_STABLE;
        endcase
    end

    // Register the step and every pin-facing output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_STABLE;
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            cke_q  <= 1'b0;
            done_q <= 1'b0;
            ref_q  <= '0;
        end else begin
            step_q <= step_n;
            cmd_q  <= cmd_n;
            ba_q   <= ba_n;
            addr_q <= addr_n;
            cke_q  <= cke_n;
            done_q <= done_n;
            ref_q  <= ref_n;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign cke       = cke_q;
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign init_done = done_q;

    // R1: no command while clock enable is low.
    a_r1_cke_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |-> (cmd_q == CMD_NOP));
    // R1: clock enable never drops once raised.
    a_r1_cke_stays: assert property (@(posedge clk) disable iff (!rst_n)
        cke_q |=> cke_q);
    // R7: a mode write is always followed by at least one NOP.
    a_r7_mrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));
    // R8: done never rises before the lock timer expires.
    a_r8_lock_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> lock_zero);
    // R9: the bus is idle with clock enable high while done.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cmd_q == CMD_NOP && cke_q));
    // R10: an accepted restart clears done.
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && restart) |=> !done_q);

endmodule

// File: tb/dram_init_seq_bench.sv
// Command-stream monitor: recomputes order, fields, gaps and done cycle.
module dram_init_seq_mon #(
    parameter int unsigned STABLE_CYC = 12,
    parameter int unsigned LOCK_CYC   = 24,
    parameter int unsigned T_RP       = 3,
    parameter int unsigned T_RFC      = 5,
    parameter int unsigned T_MRD      = 2,
    parameter int unsigned N_REF      = 2,
    parameter int unsigned CAS_LAT    = 3,
    parameter int unsigned BURST_LEN  = 8,
    parameter int unsigned BURST_TYPE = 1,
    parameter int unsigned DRIVE      = 1,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned AP_BIT     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              cke,
    input  logic [3:0]        cmd,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              done,
    output int                n_chk,
    output int                n_fail
);

    int cyc, k, last_c, last_gap, dll_c, fin_c, rs_c;
    bit prev_done, rs_pend, first_after_rs;
    int bl_code, mrs_base, emrs_exp, exp_cmd, exp_ba, exp_addr, exp_gap, exp_done;

    initial begin
        n_chk = 0; n_fail = 0;
        bl_code  = (BURST_LEN == 0) ? 7 : $clog2(BURST_LEN);
        mrs_base = bl_code + BURST_TYPE * 8 + CAS_LAT * 16;
        emrs_exp = (DRIVE % 2) * 2 + (DRIVE / 2) * 64;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %m cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; k = 0; last_c = 0; last_gap = 0; prev_done = 0;
            rs_pend = 0; first_after_rs = 0; dll_c = 0; fin_c = 0;
        end else begin
            cyc++;
            if (rs_pend && cyc == rs_c) begin
                chk(!done, "R10 done cleared", int'(done), 0);
                k = 2; rs_pend = 0; first_after_rs = 1;
            end
            if (cyc < STABLE_CYC)
                chk(!cke && cmd == 4'b0111, "R1 cke low", {27'd0, cke, cmd}, 7);
            else if (cyc == STABLE_CYC)
                chk(cke && cmd == 4'b0111, "R1 cke rise", {27'd0, cke, cmd}, 23);
            else if (!cke)
                chk(0, "R1 cke dropped", 0, 1);
            if (cmd != 4'b0111) begin
                // expected command for step k (R2 encodings)
                exp_ba = 0; exp_addr = 0;
                if (k == 0 || k == 3) begin
                    exp_cmd = 2; exp_addr = 1 << AP_BIT; exp_gap = T_RP;
                end else if (k == 1) begin
                    exp_cmd = 0; exp_ba = 1; exp_addr = emrs_exp; exp_gap = T_MRD;
                end else if (k == 2) begin
                    exp_cmd = 0; exp_addr = mrs_base + 256; exp_gap = T_MRD;
                end else if (k < 4 + N_REF) begin
                    exp_cmd = 1; exp_gap = T_RFC;
                end else if (k == 4 + N_REF) begin
                    exp_cmd = 0; exp_addr = mrs_base; exp_gap = T_MRD;
                end else begin
                    exp_cmd = 7; exp_gap = 0;
                end
                chk(int'(cmd) == exp_cmd, "R2/R3/R11 command order", int'(cmd), exp_cmd);
                if (k == 1)
                    chk(int'(ba) == exp_ba && int'(addr) == exp_addr, "R5 extended mode word",
                        int'(addr) + int'(ba) * 65536, exp_addr + exp_ba * 65536);
                else if (k == 2 || k == 4 + N_REF)
                    chk(int'(ba) == exp_ba && int'(addr) == exp_addr, "R6 mode word",
                        int'(addr) + int'(ba) * 65536, exp_addr);
                else
                    chk(int'(ba) == exp_ba && int'(addr) == exp_addr, "R4 precharge/refresh address",
                        int'(addr) + int'(ba) * 65536, exp_addr);
                if (k == 0)
                    chk(cyc == STABLE_CYC + 1, "R1 first command cycle", cyc, STABLE_CYC + 1);
                else if (first_after_rs)
                    chk(cyc == rs_c + 1, "R10 restart command cycle", cyc, rs_c + 1);
                else
                    chk(cyc - last_c == last_gap, "R7 command spacing", cyc - last_c, last_gap);
                first_after_rs = 0;
                if (k == 2) dll_c = cyc;
                if (k == 4 + N_REF) fin_c = cyc;
                last_c = cyc; last_gap = exp_gap; k++;
            end
            if (done && !prev_done) begin
                exp_done = (dll_c + LOCK_CYC > fin_c + T_MRD) ? dll_c + LOCK_CYC : fin_c + T_MRD;
                chk(k == 5 + N_REF, "R3 all commands before done", k, 5 + N_REF);
                chk(cyc == exp_done, "R8 done cycle", cyc, exp_done);
            end
            if (done && prev_done)
                chk(cmd == 4'b0111 && cke, "R9 quiet while done", {27'd0, cke, cmd}, 23);
            if (done && restart) begin
                rs_pend = 1; rs_c = cyc + 1;
            end
            prev_done = done;
        end
    end

endmodule

// Top-level bench: two configurations driven through restarts.
module dram_init_seq_bench;

    logic clk = 0;
    logic rst_n = 0;
    logic rs_a = 0, rs_b = 0;
    logic cke_a, cs_a, ras_a, cas_a, we_a, done_a;
    logic cke_b, cs_b, ras_b, cas_b, we_b, done_b;
    logic [1:0]  ba_a, ba_b;
    logic [11:0] addr_a, addr_b;
    int mchk_a, mfail_a, mchk_b, mfail_b;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dram_init_seq #(.STABLE_CYC(12), .LOCK_CYC(24), .T_RP(3), .T_RFC(5), .T_MRD(2),
        .N_REF(2), .CAS_LAT(3), .BURST_LEN(8), .BURST_TYPE(1), .DRIVE(1)) u_dram_init_seq (
        .clk(clk), .rst_n(rst_n), .restart(rs_a), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a),
        .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(addr_a), .init_done(done_a));

    dram_init_seq #(.STABLE_CYC(5), .LOCK_CYC(4), .T_RP(2), .T_RFC(3), .T_MRD(3),
        .N_REF(3), .CAS_LAT(5), .BURST_LEN(0), .BURST_TYPE(0), .DRIVE(0)) u_dram_init_seq_b (
        .clk(clk), .rst_n(rst_n), .restart(rs_b), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b),
        .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(addr_b), .init_done(done_b));

    dram_init_seq_mon #(.STABLE_CYC(12), .LOCK_CYC(24), .T_RP(3), .T_RFC(5), .T_MRD(2),
        .N_REF(2), .CAS_LAT(3), .BURST_LEN(8), .BURST_TYPE(1), .DRIVE(1)) u_mon_a (
        .clk(clk), .rst_n(rst_n), .restart(rs_a), .cke(cke_a), .cmd({cs_a, ras_a, cas_a, we_a}),
        .ba(ba_a), .addr(addr_a), .done(done_a), .n_chk(mchk_a), .n_fail(mfail_a));

    dram_init_seq_mon #(.STABLE_CYC(5), .LOCK_CYC(4), .T_RP(2), .T_RFC(3), .T_MRD(3),
        .N_REF(3), .CAS_LAT(5), .BURST_LEN(0), .BURST_TYPE(0), .DRIVE(0)) u_mon_b (
        .clk(clk), .rst_n(rst_n), .restart(rs_b), .cke(cke_b), .cmd({cs_b, ras_b, cas_b, we_b}),
        .ba(ba_b), .addr(addr_b), .done(done_b), .n_chk(mchk_b), .n_fail(mfail_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + mchk_a + mchk_b, n_fail + mfail_a + mfail_b);
    endtask

    task automatic wait_both_done();
        while (!(done_a && done_b)) @(posedge clk);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            report();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        chk(!cke_a && !done_a && {cs_a, ras_a, cas_a, we_a} == 4'b0111, "R1 reset state A",
            {cke_a, done_a}, 0);
        chk(!cke_b && !done_b && {cs_b, ras_b, cas_b, we_b} == 4'b0111, "R1 reset state B",
            {cke_b, done_b}, 0);
        @(negedge clk); #1 rst_n = 1;
        // R11: pulse restart mid-sequence on A; the monitor checks it changes nothing
        repeat (25) @(posedge clk);
        #1 rs_a = 1;
        @(posedge clk); #1 rs_a = 0;
        chk(!done_a, "R11 ignored restart keeps done low", int'(done_a), 0);
        wait_both_done();
        // R10: two accepted restarts on both instances
        for (int r = 0; r < 2; r++) begin
            repeat (5) @(posedge clk);
            #1 begin rs_a = 1; rs_b = 1; end
            @(posedge clk); #1 begin rs_a = 0; rs_b = 0; end
            chk(!done_a && !done_b, "R10 done cleared after restart", {done_a, done_b}, 0);
            wait_both_done();
        end
        repeat (10) @(posedge clk);
        chk(done_a && done_b && cke_a && cke_b, "R9 done held", {done_a, done_b}, 3);
        finished = 1;
        report();
        $finish;
    end

endmodule